// File: doc/BRIEF.md
# Six-Step Control-Bit ALU

This block is a combinational arithmetic logic unit for a 16-bit two's complement datapath. Its function is not decoded from an opcode. Six independent control inputs each switch one primitive step. Each operand can be forced to zero and then complemented. A core stage then either adds the two conditioned operands or ANDs them bit by bit. The core result can be complemented on its way out. Because the steps are chained, a few settings are enough to produce constants, negation, increment, decrement, sums, differences and bitwise logic.

Next to the result, the unit reports whether the result is zero and whether it is negative. It holds no state. A surrounding datapath drives the operands and the six control bits, and reads the result in the same cycle. The block does no multiplication, division, shifting or floating-point work.

Top module: `ctrl_alu`

## Requirements
- R1: Operand A is conditioned in a fixed order: `zero_a` forces it to zero first, then `inv_a` complements it bit by bit. With both set, A becomes all ones (-1). With neither set, A passes through unchanged.
- R2: Operand B is conditioned the same way by `zero_b` and then `inv_b`. With both set, B becomes all ones.
- R3: With `sel_add`=1 the core adds the two conditioned operands modulo 2^16, and the carry out of bit 15 is dropped (for example 0xFFFF + 0x0001 gives 0x0000).
- R4: With `sel_add`=0 the core produces the bitwise AND of the two conditioned operands.
- R5: With `inv_res`=1 the core value is complemented bit by bit before it reaches `res_o`. With `inv_res`=0 it passes through unchanged.
- R6: `is_zero_o` is 1 exactly when all 16 bits of `res_o` are 0.
- R7: `is_neg_o` is 1 exactly when bit 15 of `res_o` is 1.
- R8: The control code {zero_a,inv_a,zero_b,inv_b,sel_add,inv_res} = 6'b001110 gives A minus 1.
- R9: In the same bit order, code 6'b101010 gives 0, code 6'b111111 gives 1 and code 6'b111010 gives -1 (0xFFFF), for any operand values.
- R10: In the same bit order, code 6'b010011 gives A-B, code 6'b000111 gives B-A, code 6'b011111 gives A+1 and code 6'b001111 gives -A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A, two's complement |
| b_i | input | 16 | Operand B, two's complement |
| zero_a | input | 1 | Force A to zero (applied first) |
| inv_a | input | 1 | Complement A after the zero step |
| zero_b | input | 1 | Force B to zero (applied first) |
| inv_b | input | 1 | Complement B after the zero step |
| sel_add | input | 1 | 1: add conditioned operands, 0: bitwise AND |
| inv_res | input | 1 | Complement the core result |
| res_o | output | 16 | Final result |
| is_zero_o | output | 1 | Result is all zeros |
| is_neg_o | output | 1 | Bit 15 of the result |

## Verification
All 64 control codes are applied to operand pairs that include the corner values 0, 1, -1, 0x7FFF and 0x8000, plus pseudo-random pairs. The corner values separate the zero-then-invert order from the reverse order, because inverting first and then zeroing would turn -1 into 0 instead of keeping it at -1. They also expose wrap-around at the sign boundary (0x7FFF+1 and 0xFFFF+1). The pseudo-random pairs, which have mixed bit patterns, separate AND from addition and catch a swapped operand or a dropped complement. Directed cases then confirm the named codes, such as the constants, decrement and both subtractions, and the two flags on results that are zero, negative and most-positive.

// File: rtl/ctrl_alu_pkg.sv
package ctrl_alu_pkg;

    localparam int unsigned DATA_W = 16;

    // Field order matches the documented control-code bit order (MSB first).
    typedef struct packed {
        logic zero_a;
        logic inv_a;
        logic zero_b;
        logic inv_b;
        logic sel_add;
        logic inv_res;
    } alu_ctrl_t;

    localparam int unsigned CTRL_W = $bits(alu_ctrl_t);

    typedef enum logic {
        FN_AND = 1'b0,
        FN_ADD = 1'b1
    } core_fn_e;

    typedef struct packed {
        logic zero;
        logic neg;
    } alu_flags_t;

    localparam logic [CTRL_W-1:0] CODE_ZERO  = 6'b101010;
    localparam logic [CTRL_W-1:0] CODE_ONE   = 6'b111111;
    localparam logic [CTRL_W-1:0] CODE_MONE  = 6'b111010;
    localparam logic [CTRL_W-1:0] CODE_ADEC  = 6'b001110;

endpackage

// File: rtl/operand_cond.sv
module operand_cond #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    input  logic         zero_en,
    input  logic         inv_en,
    output logic [W-1:0] dout
);
    logic [W-1:0] zeroed;

    always_comb begin
        zeroed = zero_en ? '0 : din;
        dout   = inv_en ? ~zeroed : zeroed;
    end

    // R1 / R2: ordering of zero-then-invert, checked on the port relation
    always_comb begin
        if (zero_en && inv_en)
            p_zero_inv_ones_r1: assert ($countones(dout) == W)
                else $error("R1/R2 zero+invert did not give all ones");
        if (!zero_en && !inv_en)
            p_pass_through_r2: assert (dout == din)
                else $error("R1/R2 unconditioned operand changed");
        if (zero_en && !inv_en)
            p_zero_only_r1: assert ($countones(dout) == 0)
                else $error("R1/R2 zeroed operand not zero");
    end
endmodule

// File: rtl/core_fn.sv
module core_fn
    import ctrl_alu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  core_fn_e     fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            FN_ADD:  y = op_a + op_b;
            default: y = op_a & op_b;
        endcase
    end

    always_comb begin
        if (fn == FN_ADD)
            p_add_wrap_r3: assert (W'(y - op_b) == op_a)
                else $error("R3 sum inconsistent");
        else
            p_and_subset_r4: assert (((y & ~op_a) == '0) && ((y & ~op_b) == '0)
                                     && ($countones(y) >= $countones(op_a & op_b)))
                else $error("R4 AND result inconsistent");
    end
endmodule

// File: rtl/out_stage.sv
module out_stage
    import ctrl_alu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] y,
    input  logic         inv_en,
    output logic [W-1:0] res,
    output alu_flags_t   flags
);
    always_comb begin
        res        = inv_en ? ~y : y;
        flags.zero = ~|res;
        flags.neg  = res[W-1];
    end

    always_comb begin
        if (inv_en)
            p_out_invert_r5: assert ($countones(res ^ y) == W)
                else $error("R5 output not complemented");
        else
            p_out_pass_r5: assert ($countones(res ^ y) == 0)
                else $error("R5 output altered");
        p_zero_flag_r6: assert (flags.zero == ($countones(res) == 0))
            else $error("R6 zero flag wrong");
        p_neg_flag_r7: assert (flags.neg == ($signed(res) < 0))
            else $error("R7 negative flag wrong");
    end
endmodule

// File: rtl/ctrl_alu.sv
module ctrl_alu
    import ctrl_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         zero_a,
    input  logic         inv_a,
    input  logic         zero_b,
    input  logic         inv_b,
    input  logic         sel_add,
    input  logic         inv_res,
    output logic [W-1:0] res_o,
    output logic         is_zero_o,
    output logic         is_neg_o
);
    localparam int unsigned N_OPS = 2;

    alu_ctrl_t  ctrl;
    logic [W-1:0] raw  [N_OPS];
    logic [W-1:0] cond [N_OPS];
    logic [N_OPS-1:0] zero_sel;
    logic [N_OPS-1:0] inv_sel;
    logic [W-1:0] core_y;
    alu_flags_t   flags;

    assign ctrl     = '{zero_a: zero_a, inv_a: inv_a, zero_b: zero_b,
                        inv_b: inv_b, sel_add: sel_add, inv_res: inv_res};
    assign raw[0]   = a_i;
    assign raw[1]   = b_i;
    assign zero_sel = {ctrl.zero_b, ctrl.zero_a};
    assign inv_sel  = {ctrl.inv_b,  ctrl.inv_a};

    for (genvar i = 0; i < N_OPS; i++) begin : g_cond
        operand_cond #(.W(W)) u_cond (
            .din    (raw[i]),
            .zero_en(zero_sel[i]),
            .inv_en (inv_sel[i]),
            .dout   (cond[i])
        );
    end

    core_fn #(.W(W)) u_core (
        .op_a(cond[0]),
        .op_b(cond[1]),
        .fn  (core_fn_e'(ctrl.sel_add)),
        .y   (core_y)
    );

    out_stage #(.W(W)) u_out (
        .y     (core_y),
        .inv_en(ctrl.inv_res),
        .res   (res_o),
        .flags (flags)
    );

    assign is_zero_o = flags.zero;
    assign is_neg_o  = flags.neg;

    // Named-code checks at the block's ports
    always_comb begin
        if (ctrl == CODE_ZERO)
            p_const_zero_r9: assert (res_o == '0) else $error("R9 zero constant");
        if (ctrl == CODE_ONE)
            p_const_one_r9: assert (res_o == W'(1)) else $error("R9 one constant");
        if (ctrl == CODE_MONE)
            p_const_mone_r9: assert (res_o == '1) else $error("R9 minus-one constant");
        if (ctrl == CODE_ADEC)
            p_decrement_r8: assert (W'(res_o + W'(1)) == a_i) else $error("R8 decrement");
    end
endmodule

// File: tb/ctrl_alu_tb.sv
module ctrl_alu_tb;
    localparam int unsigned W = 16;
    localparam int unsigned NPAIR = 12;
    localparam logic [2*W-1:0] PAIRS [NPAIR] = '{
        {16'h0000, 16'h0000}, {16'h0001, 16'hFFFF}, {16'hFFFF, 16'h0001},
        {16'h7FFF, 16'h0001}, {16'h8000, 16'hFFFF}, {16'h7FFF, 16'h8000},
        {16'h0001, 16'h0001}, {16'hFFFF, 16'hFFFF}, {16'h8000, 16'h8000},
        {16'h1234, 16'h0F0F}, {16'hA5C3, 16'h3C5A}, {16'h0000, 16'h7FFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a, b, res;
    logic [5:0] code;
    logic is_zero, is_neg;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ctrl_alu u_dut (
        .a_i(a), .b_i(b),
        .zero_a(code[5]), .inv_a(code[4]), .zero_b(code[3]),
        .inv_b(code[2]), .sel_add(code[1]), .inv_res(code[0]),
        .res_o(res), .is_zero_o(is_zero), .is_neg_o(is_neg)
    );

    // Reference following the six-step definition
    function automatic logic [W-1:0] model(input logic [5:0] c,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
        logic [W-1:0] xa, yb, r;
        xa = c[5] ? 16'h0000 : x;
        if (c[4]) xa = ~xa;
        yb = c[3] ? 16'h0000 : y;
        if (c[2]) yb = ~yb;
        r = c[1] ? W'(xa + yb) : (xa & yb);
        return c[0] ? ~r : r;
    endfunction

    task automatic apply(input logic [5:0] c, input logic [W-1:0] x,
                         input logic [W-1:0] y);
        @(posedge clk);
        #1;
        code = c; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] exp_v);
        n_checks++;
        if (res !== exp_v) begin
            n_errors++;
            $display("FAIL %s code=%b a=%h b=%h actual=%h expected=%h",
                     tag, code, a, b, res, exp_v);
        end
    endtask

    task automatic check_flags(input string tag);
        n_checks++;
        if (is_zero !== (res == 16'h0) || is_neg !== res[W-1]) begin
            n_errors++;
            $display("FAIL %s flags actual=%b%b expected=%b%b res=%h",
                     tag, is_zero, is_neg, (res == 16'h0), res[W-1], res);
        end
    endtask

    initial begin
        code = 6'b0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state: AND of zeros, R4 and R6
        check("R4 idle", 16'h0000);
        check_flags("R6 idle");

        // Table sweep: all 64 codes (R1 R2 R3 R4 R5)
        for (int p = 0; p < NPAIR; p++) begin
            for (int c = 0; c < 64; c++) begin
                apply(6'(c), PAIRS[p][2*W-1:W], PAIRS[p][W-1:0]);
                check("R1/R2/R3/R4/R5 sweep", model(6'(c), a, b));
                check_flags("R6/R7 sweep");
            end
        end
        // Random operands, all codes
        for (int p = 0; p < 16; p++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            for (int c = 0; c < 64; c++) begin
                apply(6'(c), ra, rb);
                check("R3/R4/R5 random", model(6'(c), ra, rb));
                check_flags("R6/R7 random");
            end
        end

        // Directed cases
        apply(6'b110000, 16'h1234, 16'hBEEF); check("R1 A forced -1", 16'hBEEF);
        apply(6'b100000, 16'hFFFF, 16'hBEEF); check("R1 A zeroed", 16'h0000);
        apply(6'b001100, 16'hC0DE, 16'h0000); check("R2 B forced -1", 16'hC0DE);
        apply(6'b000010, 16'hFFFF, 16'h0001); check("R3 wrap", 16'h0000);
        apply(6'b000010, 16'h7FFF, 16'h0001); check("R3 sign", 16'h8000);
        apply(6'b000000, 16'hF0F0, 16'h3C3C); check("R4 and", 16'h3030);
        apply(6'b000001, 16'hF0F0, 16'h3C3C); check("R5 nand", 16'hCFCF);
        apply(6'b101010, 16'h8000, 16'h7FFF); check("R6 zero", 16'h0000);
        check_flags("R6 zero flag");
        apply(6'b000010, 16'h7FFF, 16'h0000); check("R7 max positive", 16'h7FFF);
        check_flags("R7 positive flag");
        apply(6'b001110, 16'h0000, 16'h1234); check("R8 dec 0", 16'hFFFF);
        apply(6'b001110, 16'h8000, 16'h1234); check("R8 dec min", 16'h7FFF);
        apply(6'b101010, 16'hABCD, 16'h1357); check("R9 const 0", 16'h0000);
        apply(6'b111111, 16'hABCD, 16'h1357); check("R9 const 1", 16'h0001);
        apply(6'b111010, 16'hABCD, 16'h1357); check("R9 const -1", 16'hFFFF);
        apply(6'b010011, 16'h0005, 16'h0007); check("R10 a-b", 16'hFFFE);
        apply(6'b000111, 16'h0005, 16'h0007); check("R10 b-a", 16'h0002);
        apply(6'b011111, 16'h7FFF, 16'h0000); check("R10 a+1", 16'h8000);
        apply(6'b001111, 16'h0001, 16'h0000); check("R10 neg a", 16'hFFFF);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule